// File: doc/BRIEF.md
# Parallel Port Register and Mode Control

This block is the processor-side register file of a three-port parallel I/O controller. A host accesses it through a chip select, two address bits, a data bus and separate read and write strobes. The address picks port A, port B, port C or the control register. Ports A and B are 8-bit ports. Port C is split into two independent 4-bit halves. In basic mode each of these four groups is given a direction by the control word. Output data is held in latches. Input data passes straight from the pins to the read bus.

A control write has two meanings, chosen by bit 7 of the word. When bit 7 is 1 the word is a full mode and direction definition, and it clears every output latch. When bit 7 is 0 the word is a single-bit set or clear command on port C, and it leaves the port A and port B setup alone. The group mode fields are brought out for the neighbouring handshake blocks. The block also drives per-pin output enables for the external tri-state buffers. All strobes are sampled on one system clock.

Top module: `ppi_regif`

## Requirements
- R1: While rst_ni is low and after it, the control readback is 0x9B (every group input, all modes 0), all output enables are 0 and all output latches are 0.
- R2: With cs_ni low, addr_i 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register, for both reads and writes.
- R3: With cs_ni high, writes change no latch, direction or control state.
- R4: A write takes effect on the clock edge at which wr_ni is sampled high after being sampled low on the previous edge. Holding wr_ni low changes nothing.
- R5: In a mode word (bit 7 = 1), bit 4 sets the port A direction, bit 3 the port C upper direction, bit 1 the port B direction and bit 0 the port C lower direction, with 1 meaning input. Each pin's output enable is high exactly when its group is an output.
- R6: Every mode-word write clears the port A, B and C output latches to zero.
- R7: A set/reset word (bit 7 = 0) uses bits 3:1 as the port C bit number and bit 0 as the value (1 sets, 0 clears). It changes only that port C latch bit and leaves the port A and B latches, the directions and the control readback unchanged.
- R8: Reading a group configured as output returns its latch. Reading a group configured as input returns the pins directly, not the latch.
- R9: The two port C halves follow their own directions on the same read. For example, with upper output and lower input, the read shows the upper latch bits and the lower pin bits.
- R10: While rd_ni and cs_ni are both low, data_oe_o is 1 and data_o shows the selected source combinationally. Otherwise data_oe_o is 0 and data_o is 0.
- R11: A read of the control register returns the last mode word written.
- R12: grp_a_mode_o carries bits 6:5 and grp_b_mode_o carries bit 2 of the last mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| addr_i | input | 2 | Register select |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_i | input | 8 | Write data from host |
| data_o | output | 8 | Read data to host |
| data_oe_o | output | 1 | Host data bus drive enable |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A pin drive enables |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B pin drive enables |
| pc_i | input | 8 | Port C pin inputs |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C pin drive enables |
| grp_a_mode_o | output | 2 | Group A mode field for handshake logic |
| grp_b_mode_o | output | 1 | Group B mode field for handshake logic |

## Verification
A corrupted control word shows up on the next clock edge. The output enables flip, or a read of an input group returns latch data instead of the pins. A stuck strobe edge detector either never commits a write or commits one while the strobe is still held low, and the latch outputs show this one edge after the strobe rises. A wrong set/reset bit index shows at once on pc_o, and also at the port C read once that half is an output. Whether the latches clear on a mode write can be seen by reading the group straight after the write.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned HALF_W = BUS_W / 2;
  localparam int unsigned BIT_W  = $clog2(BUS_W);
  localparam int unsigned ADDR_W = 2;

  // all groups input, all modes basic
  localparam logic [BUS_W-1:0] CTRL_RST = 8'h9B;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  typedef struct packed {
    logic [1:0] mode_a;
    logic       in_a;
    logic       in_cu;
    logic       mode_b;
    logic       in_b;
    logic       in_cl;
  } cfg_t;

  function automatic cfg_t word_to_cfg(logic [BUS_W-1:0] w);
    cfg_t c;
    c.mode_a = w[6:5];
    c.in_a   = w[4];
    c.in_cu  = w[3];
    c.mode_b = w[2];
    c.in_b   = w[1];
    c.in_cl  = w[0];
    return c;
  endfunction
endpackage

// File: rtl/ppi_bus_if.sv
module ppi_bus_if
  import ppi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  output logic              commit_o,
  output logic              rd_act_o,
  output sel_e              sel_o
);
  logic wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b1;
    else         wr_q <= wr_ni;
  end

  // low on previous edge, high now: strobe released
  assign commit_o = !wr_q && wr_ni && !cs_ni;
  assign rd_act_o = !rd_ni && !cs_ni;
  assign sel_o    = sel_e'(addr_i);
endmodule

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
  import ppi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  sel_e             sel_i,
  input  logic [BUS_W-1:0] data_i,
  output logic [BUS_W-1:0] ctrl_o,
  output cfg_t             cfg_o,
  output logic             mode_wr_o,
  output logic             bsr_wr_o,
  output logic [BIT_W-1:0] bsr_idx_o,
  output logic             bsr_val_o
);
  logic [BUS_W-1:0] ctrl_q;
  logic             ctrl_hit;

  assign ctrl_hit  = commit_i && (sel_i == SEL_CTRL);
  assign mode_wr_o = ctrl_hit && data_i[BUS_W-1];
  assign bsr_wr_o  = ctrl_hit && !data_i[BUS_W-1];
  assign bsr_idx_o = data_i[BIT_W:1];
  assign bsr_val_o = data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= CTRL_RST;
    else if (mode_wr_o) ctrl_q <= data_i;
  end

  assign ctrl_o = ctrl_q;
  assign cfg_o  = word_to_cfg(ctrl_q);
endmodule

// File: rtl/ppi_port_lane.sv
module ppi_port_lane
  import ppi_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned BASE = 0,
  parameter bit          BSR  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             clr_i,
  input  logic             bsr_en_i,
  input  logic [BIT_W-1:0] bsr_idx_i,
  input  logic             bsr_val_i,
  input  logic             dir_in_i,
  input  logic [W-1:0]     pins_i,
  output logic [W-1:0]     lat_o,
  output logic [W-1:0]     oe_o,
  output logic [W-1:0]     rd_o
);
  logic [W-1:0] lat_q, lat_d;

  always_comb begin
    lat_d = lat_q;
    if (clr_i) begin
      lat_d = '0;
    end else if (wr_en_i) begin
      lat_d = wdata_i;
    end else if (BSR && bsr_en_i) begin
      for (int k = 0; k < int'(W); k++) begin
        if (int'(bsr_idx_i) == int'(BASE) + k) lat_d[k] = bsr_val_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else         lat_q <= lat_d;
  end

  assign lat_o = lat_q;
  assign oe_o  = {W{!dir_in_i}};
  assign rd_o  = dir_in_i ? pins_i : lat_q;
endmodule

// File: rtl/ppi_regif.sv
module ppi_regif
  import ppi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [BUS_W-1:0]  data_i,
  output logic [BUS_W-1:0]  data_o,
  output logic              data_oe_o,
  input  logic [BUS_W-1:0]  pa_i,
  output logic [BUS_W-1:0]  pa_o,
  output logic [BUS_W-1:0]  pa_oe_o,
  input  logic [BUS_W-1:0]  pb_i,
  output logic [BUS_W-1:0]  pb_o,
  output logic [BUS_W-1:0]  pb_oe_o,
  input  logic [BUS_W-1:0]  pc_i,
  output logic [BUS_W-1:0]  pc_o,
  output logic [BUS_W-1:0]  pc_oe_o,
  output logic [1:0]        grp_a_mode_o,
  output logic              grp_b_mode_o
);
  logic             commit, rd_act;
  sel_e             sel;
  logic [BUS_W-1:0] ctrl_word;
  cfg_t             cfg;
  logic             mode_wr, bsr_wr, bsr_val;
  logic [BIT_W-1:0] bsr_idx;

  ppi_bus_if u_bus (
    .clk_i, .rst_ni, .cs_ni, .addr_i, .rd_ni, .wr_ni,
    .commit_o(commit), .rd_act_o(rd_act), .sel_o(sel)
  );

  ppi_ctrl_reg u_ctrl (
    .clk_i, .rst_ni, .commit_i(commit), .sel_i(sel), .data_i,
    .ctrl_o(ctrl_word), .cfg_o(cfg), .mode_wr_o(mode_wr),
    .bsr_wr_o(bsr_wr), .bsr_idx_o(bsr_idx), .bsr_val_o(bsr_val)
  );

  // full-width lanes: 0 = port A, 1 = port B
  logic [1:0][BUS_W-1:0] fw_pins, fw_lat, fw_oe, fw_rd;
  logic [1:0]            fw_dir, fw_wr;
  assign fw_pins = {pb_i, pa_i};
  assign fw_dir  = {cfg.in_b, cfg.in_a};
  assign fw_wr   = {commit && sel == SEL_B, commit && sel == SEL_A};

  for (genvar i = 0; i < 2; i++) begin : g_full
    ppi_port_lane #(.W(BUS_W), .BASE(0), .BSR(1'b0)) u_lane (
      .clk_i, .rst_ni,
      .wr_en_i(fw_wr[i]), .wdata_i(data_i), .clr_i(mode_wr),
      .bsr_en_i(1'b0), .bsr_idx_i(bsr_idx), .bsr_val_i(bsr_val),
      .dir_in_i(fw_dir[i]), .pins_i(fw_pins[i]),
      .lat_o(fw_lat[i]), .oe_o(fw_oe[i]), .rd_o(fw_rd[i])
    );
  end

  // port C halves: 0 = lower, 1 = upper
  logic [1:0][HALF_W-1:0] hw_pins, hw_lat, hw_oe, hw_rd, hw_wdata;
  logic [1:0]             hw_dir;
  assign hw_pins  = pc_i;
  assign hw_wdata = data_i;
  assign hw_dir   = {cfg.in_cu, cfg.in_cl};

  for (genvar j = 0; j < 2; j++) begin : g_half
    ppi_port_lane #(.W(HALF_W), .BASE(j * HALF_W), .BSR(1'b1)) u_lane (
      .clk_i, .rst_ni,
      .wr_en_i(commit && sel == SEL_C), .wdata_i(hw_wdata[j]), .clr_i(mode_wr),
      .bsr_en_i(bsr_wr), .bsr_idx_i(bsr_idx), .bsr_val_i(bsr_val),
      .dir_in_i(hw_dir[j]), .pins_i(hw_pins[j]),
      .lat_o(hw_lat[j]), .oe_o(hw_oe[j]), .rd_o(hw_rd[j])
    );
  end

  assign pa_o    = fw_lat[0];
  assign pb_o    = fw_lat[1];
  assign pc_o    = hw_lat;
  assign pa_oe_o = fw_oe[0];
  assign pb_oe_o = fw_oe[1];
  assign pc_oe_o = hw_oe;

  assign grp_a_mode_o = cfg.mode_a;
  assign grp_b_mode_o = cfg.mode_b;

  logic [BUS_W-1:0] rd_mux;
  always_comb begin
    unique case (sel)
      SEL_A:   rd_mux = fw_rd[0];
      SEL_B:   rd_mux = fw_rd[1];
      SEL_C:   rd_mux = hw_rd;
      default: rd_mux = ctrl_word;
    endcase
  end

  assign data_o    = rd_act ? rd_mux : '0;
  assign data_oe_o = rd_act;
endmodule

// File: rtl/ppi_regif_chk.sv
module ppi_regif_chk
  import ppi_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic [BUS_W-1:0]  data_i,
  input logic [BUS_W-1:0]  data_o,
  input logic              data_oe_o,
  input logic [BUS_W-1:0]  pa_o,
  input logic [BUS_W-1:0]  pa_oe_o,
  input logic [BUS_W-1:0]  pb_o,
  input logic [BUS_W-1:0]  pb_oe_o,
  input logic [BUS_W-1:0]  pc_o,
  input logic [BUS_W-1:0]  pc_oe_o
);
  logic wr_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_prev <= 1'b1;
    else         wr_prev <= wr_ni;
  end

  logic ctl_edge;
  assign ctl_edge = !cs_ni && !wr_prev && wr_ni && addr_i == 2'd3;

  // R3
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(pa_o) && $stable(pb_o) && $stable(pc_o) &&
              $stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o));

  // R4
  wr_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ni |=> $stable(pa_o) && $stable(pb_o) && $stable(pc_o) && $stable(pc_oe_o));

  // R6
  mode_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_edge && data_i[7]) |=> pa_o == '0 && pb_o == '0 && pc_o == '0);

  // R5
  dir_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_edge && data_i[7]) |=> pa_oe_o == {BUS_W{!$past(data_i[4])}});

  // R7
  bsr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_edge && !data_i[7]) |=> $stable(pa_o) && $stable(pb_o) &&
                                 $stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o));

  // R10
  bus_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ni || cs_ni) |-> !data_oe_o && data_o == '0);
endmodule

bind ppi_regif ppi_regif_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .addr_i(addr_i),
  .rd_ni(rd_ni), .wr_ni(wr_ni), .data_i(data_i), .data_o(data_o),
  .data_oe_o(data_oe_o), .pa_o(pa_o), .pa_oe_o(pa_oe_o), .pb_o(pb_o),
  .pb_oe_o(pb_oe_o), .pc_o(pc_o), .pc_oe_o(pc_oe_o)
);

// File: tb/ppi_regif_tb.sv
module ppi_regif_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout, pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;
  logic       dout_oe, b_mode;
  logic [1:0] a_mode;
  logic [7:0] pa_i = 8'hA5, pb_i = 8'h3C, pc_i = 8'hC3;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ppi_regif u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .addr_i(addr), .rd_ni(rd_n),
    .wr_ni(wr_n), .data_i(din), .data_o(dout), .data_oe_o(dout_oe),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe), .pb_i(pb_i), .pb_o(pb_o),
    .pb_oe_o(pb_oe), .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe),
    .grp_a_mode_o(a_mode), .grp_b_mode_o(b_mode)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic cs, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = cs; addr = a; din = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic bus_read(input logic cs, input logic [1:0] a, output logic [7:0] d,
                          output logic oe);
    @(negedge clk);
    cs_n = cs; addr = a; rd_n = 1'b0;
    #1;
    d = dout; oe = dout_oe;
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  typedef struct packed {
    logic       is_wr;
    logic [1:0] addr;
    logic [7:0] val;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC[NV] = '{
    '{1'b0, 2'd3, 8'h9B, 4'd11}, // R11 reset word
    '{1'b0, 2'd0, 8'hA5, 4'd8},  // R8 input reads pins
    '{1'b1, 2'd0, 8'h11, 4'd0},
    '{1'b0, 2'd0, 8'hA5, 4'd8},  // R8 latch hidden
    '{1'b1, 2'd3, 8'h80, 4'd0},
    '{1'b0, 2'd0, 8'h00, 4'd6},  // R6
    '{1'b0, 2'd3, 8'h80, 4'd11}, // R11
    '{1'b1, 2'd0, 8'h5E, 4'd0},
    '{1'b0, 2'd0, 8'h5E, 4'd2},  // R2 port A
    '{1'b1, 2'd1, 8'h77, 4'd0},
    '{1'b0, 2'd1, 8'h77, 4'd2},  // R2 port B
    '{1'b1, 2'd2, 8'h96, 4'd0},
    '{1'b0, 2'd2, 8'h96, 4'd2},  // R2 port C
    '{1'b1, 2'd3, 8'h0B, 4'd0},  // set bit 5
    '{1'b0, 2'd2, 8'hB6, 4'd7},  // R7
    '{1'b0, 2'd3, 8'h80, 4'd7},  // R7 readback kept
    '{1'b0, 2'd0, 8'h5E, 4'd7},  // R7 port A kept
    '{1'b0, 2'd1, 8'h77, 4'd7},  // R7 port B kept
    '{1'b1, 2'd3, 8'h02, 4'd0},  // clear bit 1
    '{1'b0, 2'd2, 8'hB4, 4'd7},  // R7
    '{1'b1, 2'd3, 8'h81, 4'd0},
    '{1'b0, 2'd2, 8'h03, 4'd9},  // R9
    '{1'b0, 2'd1, 8'h00, 4'd6},  // R6
    '{1'b1, 2'd2, 8'hF0, 4'd0},
    '{1'b0, 2'd2, 8'hF3, 4'd9},  // R9
    '{1'b1, 2'd3, 8'h01, 4'd0},  // set bit 0 under input half
    '{1'b0, 2'd2, 8'hF3, 4'd9},  // R9
    '{1'b1, 2'd3, 8'h92, 4'd0},
    '{1'b0, 2'd0, 8'hA5, 4'd8},  // R8
    '{1'b0, 2'd1, 8'h3C, 4'd8},  // R8
    '{1'b0, 2'd2, 8'h00, 4'd6}   // R6
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    logic       oe;
    #20;
    check("R1 pa_oe in reset", pa_oe, 8'h00);
    check("R1 pc_oe in reset", pc_oe, 8'h00);
    check("R1 pa_o in reset", pa_o, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_wr) begin
        bus_write(1'b0, VEC[i].addr, VEC[i].val);
      end else begin
        bus_read(1'b0, VEC[i].addr, rd, oe);
        checks++;
        if (rd !== VEC[i].val || oe !== 1'b1) begin
          fails++;
          $display("FAIL R%0d vec %0d: actual %h expected %h (oe %b)",
                   VEC[i].req, i, rd, VEC[i].val, oe);
        end
      end
    end

    // config now 0x92
    check("R5 pa_oe input", pa_oe, 8'h00);
    check("R5 pb_oe input", pb_oe, 8'h00);
    check("R5 pc_oe output", pc_oe, 8'hFF);

    bus_write(1'b1, 2'd3, 8'h80);
    check("R3 cs high write ignored", pa_oe, 8'h00);
    bus_read(1'b0, 2'd3, rd, oe);
    check("R3 ctrl unchanged", rd, 8'h92);
    bus_read(1'b1, 2'd0, rd, oe);
    check("R10 data_o idle", rd, 8'h00);
    check("R10 data_oe idle", {7'd0, oe}, 8'h00);

    bus_write(1'b0, 2'd3, 8'h81);
    check("R5 pa_oe output", pa_oe, 8'hFF);
    check("R5 pc_oe split", pc_oe, 8'hF0);
    check("R12 a mode", {6'd0, a_mode}, 8'h00);

    // R4 strobe held low
    @(negedge clk);
    cs_n = 1'b0; addr = 2'd0; din = 8'h3D; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 held low no effect", pa_o, 8'h00);
    wr_n = 1'b1;
    #1;
    check("R4 before edge", pa_o, 8'h00);
    @(negedge clk);
    check("R4 after rising edge", pa_o, 8'h3D);
    cs_n = 1'b1;

    bus_write(1'b0, 2'd3, 8'h0F);
    check("R7 pc_o bit7 set", pc_o, 8'h80);
    check("R7 pa_o kept", pa_o, 8'h3D);

    bus_write(1'b0, 2'd3, 8'hC4);
    check("R12 a mode field", {6'd0, a_mode}, 8'h02);
    check("R12 b mode field", {7'd0, b_mode}, 8'h01);
    check("R6 pa_o cleared", pa_o, 8'h00);

    bus_write(1'b0, 2'd0, 8'h44);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 pa_o after reset", pa_o, 8'h00);
    check("R1 pa_oe after reset", pa_oe, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    bus_read(1'b0, 2'd3, rd, oe);
    check("R1 ctrl after reset", rd, 8'h9B);

    finish_run();
  end
endmodule